// File: doc/BRIEF.md
# Scoped Synchronization Broadcast Sequencer

This block sits in a shared second-level cache controller. It turns scoped acquire and release requests from `NUM_L1` private first-level caches into cache maintenance commands. Each request names the requester, says whether it is an acquire or a release, and gives a scope. The block works out which caches must be flushed or invalidated and pulses those command lines. It then collects one acknowledgement per commanded cache and sends a done response back to the requester.

Workgroup-scope requests finish at once with no maintenance. Agent-scope requests touch only the requester's own cache. Remote-agent-scope requests touch the requester and also broadcast to every other cache. A remote-agent request that writes a value is wrapped in a global lock step before its commands and a global unlock step after them. The sequencer holds only one request at a time, so remote operations never overlap.

Top module: `scope_sync_seq`

## Requirements
- R1: A request with scope code 0 (workgroup) produces no flush and no invalidate command. `done_valid` is high with `done_id` equal to the requester in the cycle right after acceptance. `req_write` has no effect on it.
- R2: An acquire (`req_is_rel`=0) with scope code 1 (agent) pulses `inv_cmd` only on bit `req_id` and pulses no flush.
- R3: A release (`req_is_rel`=1) with scope code 1 pulses `flush_cmd` only on bit `req_id` and pulses no invalidate. `req_write` is ignored at this scope.
- R4: An acquire with scope code 2 (remote agent) pulses `inv_cmd` on bit `req_id` and pulses `flush_cmd` on every other bit.
- R5: A release with scope code 2 pulses `flush_cmd` on bit `req_id` and pulses `inv_cmd` on every other bit.
- R6: `done_valid` rises only after every commanded cache has acknowledged on its `l1_ack` bit. Acknowledgements on bits that were not commanded are ignored. Without a lock step, done is visible in the cycle after the cycle in which the last needed acknowledgement is high. `done_id` always equals the requester.
- R7: A remote-agent request with `req_write`=1 first holds `glock_req` high, with no commands, until `glock_ack`. Its commands come in the cycle after the grant. After the last acknowledgement it holds `gunlock_req` high until `glock_ack`. Done follows in the next cycle, which is two cycles after the last acknowledgement cycle.
- R8: `req_ready` is low from the cycle after acceptance through the done cycle, and high again the cycle after done. A request presented while busy is not taken, so remote operations are serialized.
- R9: Scope code 3 behaves exactly as scope code 2, including the lock step when `req_write`=1.
- R10: Each cache receives at most one command per request. Commands are one-cycle pulses: in the cycle after acceptance, or in the cycle after the lock grant.
- R11: During and right after reset, `req_ready` is high and every command, lock and done output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_id | input | ID_W | Requesting cache index |
| req_is_rel | input | 1 | 1 = release, 0 = acquire |
| req_scope | input | 2 | 0 workgroup, 1 agent, 2 or 3 remote agent |
| req_write | input | 1 | Remote operation writes a value (needs lock step) |
| flush_cmd | output | NUM_L1 | Per-cache flush command pulse |
| inv_cmd | output | NUM_L1 | Per-cache invalidate command pulse |
| l1_ack | input | NUM_L1 | Per-cache command completion pulse |
| glock_req | output | 1 | Global lock request, held until acknowledged |
| gunlock_req | output | 1 | Global unlock request, held until acknowledged |
| glock_ack | input | 1 | Global lock or unlock acknowledgement |
| done_valid | output | 1 | One-cycle completion response |
| done_id | output | ID_W | Requester the response belongs to |

## Verification
A workgroup request shows done one cycle after acceptance. Agent and remote commands show one cycle after acceptance, or one cycle after the lock grant. Done comes one cycle after the last acknowledgement, or two cycles when an unlock step sits between them. The bench drives inputs and samples outputs one time unit after each falling edge. A falling-edge cycle counter records when the cache stubs raise their last acknowledgement, and the done cycle is compared with that count plus the expected gap. A stray acknowledgement pattern and two different stub delay patterns show that done waits for every commanded cache and no others.

// File: rtl/ssq_pkg.sv
`timescale 1ns/1ps
package ssq_pkg;

    typedef enum logic [1:0] {
        SCOPE_WG      = 2'd0,
        SCOPE_AGENT   = 2'd1,
        SCOPE_REMOTE  = 2'd2,
        SCOPE_REMOTE2 = 2'd3
    } scope_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK,
        ST_ISSUE,
        ST_WAIT,
        ST_UNLOCK,
        ST_RESP
    } state_e;

    // Maintenance work implied by one request
    typedef struct packed {
        logic need_lock;
        logic self_flush;
        logic self_inv;
        logic peer_flush;
        logic peer_inv;
    } plan_t;

    function automatic plan_t plan_of(input logic [1:0] scope,
                                      input logic is_rel,
                                      input logic wr);
        plan_t p;
        p = '0;
        case (scope_e'(scope))
            SCOPE_WG: ;
            SCOPE_AGENT: begin
                p.self_flush = is_rel;
                p.self_inv   = !is_rel;
            end
            default: begin
                p.self_flush = is_rel;
                p.peer_inv   = is_rel;
                p.self_inv   = !is_rel;
                p.peer_flush = !is_rel;
                p.need_lock  = wr;
            end
        endcase
        return p;
    endfunction

    function automatic logic plan_quiet(input plan_t p);
        return !(p.self_flush | p.self_inv | p.peer_flush | p.peer_inv);
    endfunction

endpackage

// File: rtl/ssq_target_map.sv
`timescale 1ns/1ps
module ssq_target_map
    import ssq_pkg::*;
#(
    parameter int NUM_L1 = 8,
    parameter int ID_W   = 3
) (
    input  logic [ID_W-1:0]   self_id,
    input  plan_t             plan,
    output logic [NUM_L1-1:0] flush_mask,
    output logic [NUM_L1-1:0] inv_mask
);

    for (genvar i = 0; i < NUM_L1; i++) begin : g_port
        logic is_self;
        assign is_self       = (self_id == ID_W'(i));
        assign flush_mask[i] = is_self ? plan.self_flush : plan.peer_flush;
        assign inv_mask[i]   = is_self ? plan.self_inv   : plan.peer_inv;
    end

endmodule

// File: rtl/ssq_pending.sv
`timescale 1ns/1ps
module ssq_pending #(
    parameter int NUM_L1 = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NUM_L1-1:0] load_mask,
    input  logic [NUM_L1-1:0] ack,
    output logic              all_clear_next
);

    logic [NUM_L1-1:0] pend;

    for (genvar i = 0; i < NUM_L1; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (load)
                pend[i] <= load_mask[i];
            else if (ack[i])
                pend[i] <= 1'b0;
        end
    end

    // Acks for bits never commanded fall away here
    assign all_clear_next = ~|(pend & ~ack);

endmodule

// File: rtl/ssq_ctrl.sv
`timescale 1ns/1ps
module ssq_ctrl
    import ssq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  plan_t in_plan,
    input  logic  q_need_lock,
    input  logic  glock_ack,
    input  logic  all_clear_next,
    output logic  req_ready,
    output logic  accept,
    output logic  issue,
    output logic  glock_req,
    output logic  gunlock_req,
    output logic  done_valid
);

    state_e state, state_nx;

    assign req_ready   = (state == ST_IDLE);
    assign accept      = req_ready && req_valid;
    assign issue       = (state == ST_ISSUE);
    assign glock_req   = (state == ST_LOCK);
    assign gunlock_req = (state == ST_UNLOCK);
    assign done_valid  = (state == ST_RESP);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (plan_quiet(in_plan))
                        state_nx = ST_RESP;
                    else if (in_plan.need_lock)
                        state_nx = ST_LOCK;
                    else
                        state_nx = ST_ISSUE;
                end
            end
            ST_LOCK:   if (glock_ack) state_nx = ST_ISSUE;
            ST_ISSUE:  state_nx = ST_WAIT;
            ST_WAIT:   if (all_clear_next) state_nx = q_need_lock ? ST_UNLOCK : ST_RESP;
            ST_UNLOCK: if (glock_ack) state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

endmodule

// File: rtl/scope_sync_seq.sv
`timescale 1ns/1ps
module scope_sync_seq
    import ssq_pkg::*;
#(
    parameter  int NUM_L1 = 8,
    localparam int ID_W   = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_is_rel,
    input  logic [1:0]        req_scope,
    input  logic              req_write,
    output logic [NUM_L1-1:0] flush_cmd,
    output logic [NUM_L1-1:0] inv_cmd,
    input  logic [NUM_L1-1:0] l1_ack,
    output logic              glock_req,
    output logic              gunlock_req,
    input  logic              glock_ack,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id
);

    plan_t             in_plan, q_plan;
    logic [ID_W-1:0]   q_id;
    logic              accept, issue, all_clear_next;
    logic [NUM_L1-1:0] flush_mask, inv_mask, cmd_mask;

    assign in_plan = plan_of(req_scope, req_is_rel, req_write);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_plan <= '0;
            q_id   <= '0;
        end else if (accept) begin
            q_plan <= in_plan;
            q_id   <= req_id;
        end
    end

    ssq_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .in_plan        (in_plan),
        .q_need_lock    (q_plan.need_lock),
        .glock_ack      (glock_ack),
        .all_clear_next (all_clear_next),
        .req_ready      (req_ready),
        .accept         (accept),
        .issue          (issue),
        .glock_req      (glock_req),
        .gunlock_req    (gunlock_req),
        .done_valid     (done_valid)
    );

    ssq_target_map #(.NUM_L1(NUM_L1), .ID_W(ID_W)) u_map (
        .self_id    (q_id),
        .plan       (q_plan),
        .flush_mask (flush_mask),
        .inv_mask   (inv_mask)
    );

    assign cmd_mask = flush_mask | inv_mask;

    ssq_pending #(.NUM_L1(NUM_L1)) u_pending (
        .clk            (clk),
        .rst            (rst),
        .load           (issue),
        .load_mask      (cmd_mask),
        .ack            (l1_ack),
        .all_clear_next (all_clear_next)
    );

    assign flush_cmd = issue ? flush_mask : '0;
    assign inv_cmd   = issue ? inv_mask   : '0;
    assign done_id   = q_id;

endmodule

// File: rtl/ssq_checker.sv
`timescale 1ns/1ps
module ssq_checker #(
    parameter int NUM_L1 = 8,
    parameter int ID_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ID_W-1:0]   req_id,
    input logic              req_is_rel,
    input logic [1:0]        req_scope,
    input logic              req_write,
    input logic [NUM_L1-1:0] flush_cmd,
    input logic [NUM_L1-1:0] inv_cmd,
    input logic [NUM_L1-1:0] l1_ack,
    input logic              glock_req,
    input logic              gunlock_req,
    input logic              done_valid,
    input logic [ID_W-1:0]   done_id
);

    logic [ID_W-1:0]   id_q;
    logic [NUM_L1-1:0] outstanding;
    logic [NUM_L1-1:0] self_bit;
    logic              acc;

    assign acc      = req_valid && req_ready;
    assign self_bit = NUM_L1'(1) << id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q        <= '0;
            outstanding <= '0;
        end else begin
            if (acc) id_q <= req_id;
            outstanding <= (outstanding & ~l1_ack) | flush_cmd | inv_cmd;
        end
    end

    a_r1_wg_no_action: assert property (@(posedge clk) disable iff (rst)
        (acc && req_scope == 2'd0) |=> (done_valid && flush_cmd == '0 && inv_cmd == '0));

    a_r2_agent_acquire: assert property (@(posedge clk) disable iff (rst)
        (acc && req_scope == 2'd1 && !req_is_rel) |=> (flush_cmd == '0 && inv_cmd == self_bit));

    a_r3_agent_release: assert property (@(posedge clk) disable iff (rst)
        (acc && req_scope == 2'd1 && req_is_rel) |=> (inv_cmd == '0 && flush_cmd == self_bit));

    a_r4_remote_acquire: assert property (@(posedge clk) disable iff (rst)
        (acc && req_scope[1] && !req_write && !req_is_rel) |=>
            (inv_cmd == self_bit && flush_cmd == ~self_bit));

    a_r5_remote_release: assert property (@(posedge clk) disable iff (rst)
        (acc && req_scope[1] && !req_write && req_is_rel) |=>
            (flush_cmd == self_bit && inv_cmd == ~self_bit));

    a_r6_done_after_acks: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (outstanding == '0));

    a_r6_done_id: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_id == id_q));

    a_r7_lock_before_cmd: assert property (@(posedge clk) disable iff (rst)
        glock_req |-> (flush_cmd == '0 && inv_cmd == '0 && !gunlock_req));

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        acc |=> !req_ready);

    a_r10_one_cmd_each: assert property (@(posedge clk) disable iff (rst)
        (flush_cmd & inv_cmd) == '0);

    a_r10_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
        (|(flush_cmd | inv_cmd)) |=> (flush_cmd == '0 && inv_cmd == '0));

endmodule

bind scope_sync_seq ssq_checker #(.NUM_L1(NUM_L1), .ID_W(ID_W)) u_ssq_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_id      (req_id),
    .req_is_rel  (req_is_rel),
    .req_scope   (req_scope),
    .req_write   (req_write),
    .flush_cmd   (flush_cmd),
    .inv_cmd     (inv_cmd),
    .l1_ack      (l1_ack),
    .glock_req   (glock_req),
    .gunlock_req (gunlock_req),
    .done_valid  (done_valid),
    .done_id     (done_id)
);

// File: tb/test_scope_sync_seq.sv
`timescale 1ns/1ps
module test_scope_sync_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_L1     = 8;
    localparam int ID_W       = 3;

    typedef struct packed {
        logic [2:0] id;
        logic       rel;
        logic [1:0] scope;
        logic       wr;
        logic       lock;
        logic [7:0] fl;
        logic [7:0] iv;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00},
        '{3'd5, 1'b1, 2'd0, 1'b1, 1'b0, 8'h00, 8'h00},
        '{3'd3, 1'b0, 2'd1, 1'b0, 1'b0, 8'h00, 8'h08},
        '{3'd0, 1'b1, 2'd1, 1'b1, 1'b0, 8'h01, 8'h00},
        '{3'd6, 1'b0, 2'd2, 1'b0, 1'b0, 8'hBF, 8'h40},
        '{3'd1, 1'b1, 2'd2, 1'b0, 1'b0, 8'h02, 8'hFD},
        '{3'd7, 1'b0, 2'd2, 1'b1, 1'b1, 8'h7F, 8'h80},
        '{3'd4, 1'b1, 2'd2, 1'b1, 1'b1, 8'h10, 8'hEF},
        '{3'd0, 1'b0, 2'd3, 1'b0, 1'b0, 8'hFE, 8'h01},
        '{3'd7, 1'b1, 2'd3, 1'b1, 1'b1, 8'h80, 8'h7F}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ID_W-1:0]   req_id = '0;
    logic              req_is_rel = 1'b0;
    logic [1:0]        req_scope = '0;
    logic              req_write = 1'b0;
    logic [NUM_L1-1:0] flush_cmd, inv_cmd;
    logic [NUM_L1-1:0] l1_ack = '0;
    logic              glock_req, gunlock_req;
    logic              glock_ack = 1'b0;
    logic              done_valid;
    logic [ID_W-1:0]   done_id;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // L1 stub state
    int cnt [NUM_L1];
    int dly [NUM_L1];
    int cyc = 0;
    int last_ack = 0;
    logic gl_hold = 1'b0;
    logic [NUM_L1-1:0] stray = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scope_sync_seq #(.NUM_L1(NUM_L1)) i_scope_sync_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_is_rel(req_is_rel), .req_scope(req_scope),
        .req_write(req_write), .flush_cmd(flush_cmd), .inv_cmd(inv_cmd),
        .l1_ack(l1_ack), .glock_req(glock_req), .gunlock_req(gunlock_req),
        .glock_ack(glock_ack), .done_valid(done_valid), .done_id(done_id)
    );

    // Cache and lock stubs, updated on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = 0; i < NUM_L1; i++) begin
            l1_ack[i] = stray[i];
            if (rst) begin
                cnt[i] = 0;
            end else begin
                if (cnt[i] != 0) begin
                    cnt[i] = cnt[i] - 1;
                    if (cnt[i] == 0) begin
                        l1_ack[i] = 1'b1;
                        last_ack  = cyc;
                    end
                end
                if (flush_cmd[i] || inv_cmd[i]) cnt[i] = dly[i];
            end
        end
        glock_ack = !rst && ((glock_req && !gl_hold) || gunlock_req);
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.scope == 2'd3) return "R9";
        if (v.scope == 2'd2) return v.rel ? "R5" : "R4";
        return v.rel ? "R3" : "R2";
    endfunction

    task automatic run_vec(input vec_t v);
        bit saw_extra, saw_unlock;
        int n;
        req_id = v.id; req_is_rel = v.rel; req_scope = v.scope; req_write = v.wr;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        chk(!req_ready, "R8 busy after accept", {31'd0, req_ready}, 0);
        if (v.scope == 2'd0) begin
            chk(done_valid && done_id == v.id && flush_cmd == '0 && inv_cmd == '0,
                "R1 workgroup done", {done_valid, done_id, flush_cmd, inv_cmd}, {1'b1, v.id, 16'h0});
            step();
            chk(req_ready, "R8 ready after done", {31'd0, req_ready}, 1);
            return;
        end
        if (v.lock) begin
            chk(glock_req && flush_cmd == '0 && inv_cmd == '0, "R7 lock first",
                {glock_req, flush_cmd, inv_cmd}, {1'b1, 16'h0});
            step();
        end
        chk(flush_cmd == v.fl, {tag_of(v), " flush"}, flush_cmd, v.fl);
        chk(inv_cmd == v.iv, {tag_of(v), " invalidate"}, inv_cmd, v.iv);
        saw_extra = 0; saw_unlock = 0; n = 0;
        do begin
            step();
            if (flush_cmd != '0 || inv_cmd != '0) saw_extra = 1;
            if (gunlock_req) saw_unlock = 1;
            n++;
        end while (!done_valid && n < 200);
        chk(!saw_extra, "R10 single pulse", {31'd0, saw_extra}, 0);
        if (v.lock) chk(saw_unlock, "R7 unlock step", {31'd0, saw_unlock}, 1);
        chk(done_valid && done_id == v.id, "R6 done id", {done_valid, done_id}, {1'b1, v.id});
        chk(cyc == last_ack + (v.lock ? 2 : 1), "R6 done timing", cyc, last_ack + (v.lock ? 2 : 1));
        step();
        chk(req_ready && !done_valid, "R8 ready after done", {req_ready, done_valid}, 2'b10);
    endtask

    initial begin
        for (int i = 0; i < NUM_L1; i++) begin
            cnt[i] = 0;
            dly[i] = i + 1;
        end
        repeat (3) step();
        // R11 reset state, during reset
        chk(req_ready && !done_valid && flush_cmd == '0 && inv_cmd == '0 && !glock_req && !gunlock_req,
            "R11 in reset", {req_ready, done_valid, glock_req, gunlock_req}, 4'b1000);
        rst = 1'b0;
        step();
        chk(req_ready && !done_valid && flush_cmd == '0 && inv_cmd == '0 && !glock_req && !gunlock_req,
            "R11 after reset", {req_ready, done_valid, glock_req, gunlock_req}, 4'b1000);

        // Table pass with rising stub delays
        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

        // Table pass with falling stub delays
        for (int i = 0; i < NUM_L1; i++) dly[i] = NUM_L1 - i;
        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

        // R6: stray acknowledgements on uncommanded caches are ignored
        for (int i = 0; i < NUM_L1; i++) dly[i] = 5;
        stray = 8'hFB;
        run_vec('{3'd2, 1'b0, 2'd1, 1'b0, 1'b0, 8'h00, 8'h04});
        stray = '0;

        // R8: a second request waits while a locked remote release is stalled
        gl_hold = 1'b1;
        req_id = 3'd3; req_is_rel = 1'b1; req_scope = 2'd2; req_write = 1'b1;
        req_valid = 1'b1;
        step();
        req_id = 3'd5; req_is_rel = 1'b0; req_scope = 2'd1; req_write = 1'b0;
        for (int j = 0; j < 6; j++) begin
            step();
            chk(!req_ready && glock_req && flush_cmd == '0 && inv_cmd == '0 && !done_valid,
                "R8 stalled while locked", {req_ready, glock_req, done_valid}, 3'b010);
        end
        req_valid = 1'b0;
        gl_hold = 1'b0;
        begin
            int n;
            n = 0;
            do begin
                step();
                n++;
            end while (!done_valid && n < 200);
        end
        chk(done_valid && done_id == 3'd3, "R8 first request completes", {done_valid, done_id}, {1'b1, 3'd3});
        step();
        step();
        chk(req_ready && flush_cmd == '0 && inv_cmd == '0 && !done_valid,
            "R8 held request not taken", {req_ready, done_valid}, 2'b10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule